// File: doc/BRIEF.md
# Pseudo-Random One-of-Sixteen Output Selector

This block picks one of sixteen outputs in a scrambled order. A 16-bit shift register steps once on each clock where the step enable is high. The new bit that enters stage 0 is made from two upper stages. The four lowest stages form an index, and a decoder turns that index into a 16-bit one-hot select. The register, the index and the select all hold while the enable is low. The logic is fully synchronous, so only the rate of the enable sets the selection rate. A slow design rate such as 12.5 kHz is set by enable pulses from a faster clock.

Pure XOR feedback never reaches the all-zero state of the feedback core. Because of that, index 0000 comes up one time fewer per period than every other index. A mode input chooses between that plain sequence and an extended sequence. In extended mode, a NOR term on the feedback splices the all-zero core state into the loop. Every index then appears exactly as often as every other.

Top module: `rand_onehot_sel`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) loads the register with 0x0001. After the reset, sel_index reads 1 and sel_onehot reads 0x0002.
- R2: On a clock edge with step_en low and rst_n high, sr_state, sel_index and sel_onehot keep their values.
- R3: On each enabled edge, the register shifts one place toward the MSB. The new bits 15..1 equal the old bits 14..0.
- R4: In plain mode (full_cycle = 0), the new bit 0 is old bit 14 XOR old bit 13.
- R5: In plain mode, starting from the seed, the core (bits 14..0) returns to 0x0001 after 32767 enabled steps. Over those steps, index 0 occurs 2047 times and each other index occurs 2048 times.
- R6: In extended mode (full_cycle = 1), a core of 0x4000 steps to a core of 0x0000, and a core of 0x0000 steps to 0x0001. Every other core value steps as in R4.
- R7: In extended mode, the core returns to its start after 32768 enabled steps, and each of the 16 index values occurs exactly 2048 times.
- R8: sel_index always equals sr_state[3:0]. sel_onehot has exactly one bit set, and that bit is bit sel_index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every flop updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; loads the seed |
| step_en | input | 1 | Advances the sequence by one step when high |
| full_cycle | input | 1 | 0: plain XOR feedback; 1: all-zero state spliced in |
| sel_onehot | output | 16 | One-hot select driven from the current index |
| sel_index | output | 4 | Current index, taken from register bits 3..0 |
| sr_state | output | 16 | Full shift register contents |

## Verification
The bench tallies every index over one whole period in each mode. It expects 2047 zeros in plain mode and exactly 2048 of every index in extended mode. A wrong NOR term or a wrong NOR span would show up as a skewed tally or a period that does not close, or as a register that sticks at zero. The bench watches the 0x4000 → 0x0000 → 0x0001 splice directly, so an off-by-one in the inserted state is caught at the step where it happens. A per-clock reference model also catches wrong taps, a missed hold when step_en is low, and a wrong reset seed.

// File: rtl/rsel_pkg.sv
// Package: shared mode type and helpers for the one-of-sixteen selector.
// Assumes: nothing beyond IEEE 1800-2017.
package rsel_pkg;

    // Feedback mode: plain linear sequence, or the sequence with the zero state spliced in
    typedef enum logic {
        MODE_PLAIN = 1'b0,
        MODE_FULL  = 1'b1
    } fb_mode_e;

endpackage

// File: rtl/rsel_shift_core.sv
// Module: shift register with two-tap XOR feedback and optional zero-state splice.
// Assumes: TAP_HI > TAP_LO, TAP_HI < WIDTH. The core is made of bits TAP_HI..0;
// bits above TAP_HI are delayed copies. The seed's core part is nonzero.
module rsel_shift_core
    import rsel_pkg::*;
#(
    parameter int          WIDTH  = 16,
    parameter int          TAP_HI = 14,
    parameter int          TAP_LO = 13,
    parameter logic [WIDTH-1:0] SEED = 16'h0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  fb_mode_e         mode,
    output logic [WIDTH-1:0] state_o
);
    localparam int CORE_W = TAP_HI + 1;

    logic [WIDTH-1:0] sr_q;
    logic             lin_bit;
    logic             low_all_zero;
    logic             fb_bit;

    // Linear part of the feedback and detector for "all core stages but the top one are zero"
    always_comb begin
        lin_bit      = sr_q[TAP_HI] ^ sr_q[TAP_LO];
        low_all_zero = ~|sr_q[TAP_HI-1:0];
        fb_bit       = (mode == MODE_FULL) ? (lin_bit ^ low_all_zero) : lin_bit;
    end

    // Register update: reset to seed, hold when idle, otherwise shift toward the MSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= SEED;
        end else if (step_en) begin
            sr_q <= {sr_q[WIDTH-2:0], fb_bit};
        end
    end

    assign state_o = sr_q;

    // Records that the previous edge was a reset edge (checker helper only)
    logic rst_prev_q;
    always_ff @(posedge clk) rst_prev_q <= !rst_n;

    assert_seed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_prev_q |-> sr_q == SEED);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(sr_q));

    assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> sr_q[WIDTH-1:1] == $past(sr_q[WIDTH-2:0]));

    assert_enter_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && mode == MODE_FULL && sr_q[CORE_W-1:0] == {1'b1, {(CORE_W-1){1'b0}}})
        |=> sr_q[CORE_W-1:0] == '0);

    assert_leave_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && mode == MODE_FULL && sr_q[CORE_W-1:0] == '0)
        |=> sr_q[CORE_W-1:0] == {{(CORE_W-1){1'b0}}, 1'b1});

    assert_plain_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && mode == MODE_PLAIN && sr_q[CORE_W-1:0] == {1'b1, {(CORE_W-1){1'b0}}})
        |=> sr_q[CORE_W-1:0] == {{(CORE_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/rsel_onehot_dec.sv
// Module: binary index to one-hot decoder.
// Assumes: OUT_N == 2**IDX_W; purely combinational.
module rsel_onehot_dec #(
    parameter int IDX_W = 4,
    parameter int OUT_N = 16
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [OUT_N-1:0] dec_o
);
    // One comparator per output line
    for (genvar g = 0; g < OUT_N; g++) begin : g_line
        assign dec_o[g] = (idx_i == IDX_W'(g));
    end
endmodule

// File: rtl/rand_onehot_sel.sv
// Module: top of the pseudo-random one-of-sixteen selector.
// Assumes: synchronous active-low reset; the index comes from register bits IDX_LSB+IDX_W-1..IDX_LSB.
module rand_onehot_sel
    import rsel_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int TAP_HI  = 14,
    parameter int TAP_LO  = 13,
    parameter int IDX_W   = 4,
    parameter int IDX_LSB = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  logic                full_cycle,
    output logic [(1<<IDX_W)-1:0] sel_onehot,
    output logic [IDX_W-1:0]    sel_index,
    output logic [WIDTH-1:0]    sr_state
);
    localparam int OUT_N = 1 << IDX_W;

    fb_mode_e mode;
    assign mode = full_cycle ? MODE_FULL : MODE_PLAIN;

    // Sequence generator
    rsel_shift_core #(
        .WIDTH  (WIDTH),
        .TAP_HI (TAP_HI),
        .TAP_LO (TAP_LO),
        .SEED   (WIDTH'(1))
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .mode    (mode),
        .state_o (sr_state)
    );

    assign sel_index = sr_state[IDX_LSB +: IDX_W];

    // Index decoder
    rsel_onehot_dec #(
        .IDX_W (IDX_W),
        .OUT_N (OUT_N)
    ) u_dec (
        .idx_i (sel_index),
        .dec_o (sel_onehot)
    );

    assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_onehot) == 1 && sel_onehot[sel_index]);

endmodule

// File: tb/rand_onehot_sel_bench.sv
module rand_onehot_sel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        full_cycle = 1'b0;
    logic [15:0] sel_onehot;
    logic [3:0]  sel_index;
    logic [15:0] sr_state;

    int checks = 0;
    int fails = 0;
    bit chk_on = 1'b0;
    int m_state = 1;
    int tally [16];
    int zero_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rand_onehot_sel u_rand_onehot_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .full_cycle (full_cycle),
        .sel_onehot (sel_onehot),
        .sel_index  (sel_index),
        .sr_state   (sr_state)
    );

    // Behavioural reference: integer model of the requirements
    always @(posedge clk) begin
        if (!rst_n) m_state = 1;
        else if (step_en) begin
            int fb;
            fb = ((m_state >> 14) ^ (m_state >> 13)) & 1;
            if (full_cycle && (m_state % 16384) == 0) fb = fb ^ 1;
            m_state = ((m_state * 2) + fb) % 65536;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (chk_on && rst_n) begin
            check(sr_state == 16'(m_state), "R3/R4/R6 state", sr_state, m_state);
            check(sel_index == 4'(m_state % 16), "R8 index", sel_index, m_state % 16);
            check(sel_onehot == 16'(1 << (m_state % 16)), "R8 onehot", sel_onehot, 1 << (m_state % 16));
        end
    end

    task automatic run_period(input int steps, input bit ext);
        foreach (tally[i]) tally[i] = 0;
        zero_seen = 0;
        @(negedge clk);
        full_cycle = ext;
        step_en = 1'b1;
        for (int k = 0; k < steps; k++) begin
            @(negedge clk);
            tally[sel_index]++;
            if (sr_state[14:0] == 15'h0) zero_seen++;
        end
        step_en = 1'b0;
    endtask

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sr_state == 16'h0001, "R1 state", sr_state, 16'h0001);
        check(sel_index == 4'd1, "R1 index", sel_index, 1);
        check(sel_onehot == 16'h0002, "R1 onehot", sel_onehot, 16'h0002);
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R3/R4: a few steps from the seed
        step_en = 1'b1;
        repeat (3) @(negedge clk);
        check(sr_state == 16'h0008, "R3 three shifts", sr_state, 16'h0008);
        // R2: hold with enable low
        step_en = 1'b0;
        held = sr_state;
        repeat (4) @(negedge clk);
        check(sr_state == held, "R2 hold", sr_state, held);
        // Restart from seed for a clean period
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(sr_state == 16'h0001, "R1 reseed", sr_state, 16'h0001);
        // R5: plain period and index tally
        run_period(32767, 1'b0);
        check(sr_state[14:0] == 15'h0001, "R5 period closes", sr_state[14:0], 1);
        check(tally[0] == 2047, "R5 zero deficit", tally[0], 2047);
        for (int i = 1; i < 16; i++)
            check(tally[i] == 2048, "R5 index tally", tally[i], 2048);
        check(zero_seen == 0, "R4 no zero core", zero_seen, 0);
        // R7: extended period and index tally
        run_period(32768, 1'b1);
        check(sr_state[14:0] == 15'h0001, "R7 period closes", sr_state[14:0], 1);
        for (int i = 0; i < 16; i++)
            check(tally[i] == 2048, "R7 index tally", tally[i], 2048);
        check(zero_seen == 1, "R6 zero visited once", zero_seen, 1);
        // R6: explicit splice, stepping into and out of zero
        full_cycle = 1'b1;
        step_en = 1'b1;
        while (sr_state[14:0] != 15'h4000) @(negedge clk);
        @(negedge clk);
        check(sr_state[14:0] == 15'h0000, "R6 enter zero", sr_state[14:0], 0);
        @(negedge clk);
        check(sr_state[14:0] == 15'h0001, "R6 leave zero", sr_state[14:0], 1);
        step_en = 1'b0;
        // R1: reset in mid-run
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(sr_state == 16'h0001, "R1 mid-run reset", sr_state, 16'h0001);
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule